// File: doc/BRIEF.md
# Address Translation Unit with Set-Associative Translation Cache

This block translates 14-bit virtual addresses into 12-bit physical addresses for a memory system with 64-byte pages. The low 6 address bits are the page offset and pass through unchanged. The upper 8 bits form the virtual page number. A 16-entry translation cache, organised as 4 sets of 4 ways, holds recently used page mappings. When the cache does not hold a mapping, the block falls back to a 256-entry single-level page table. That table is indexed directly by the virtual page number.

A requester presents an address while `req_ready` is high. A cache hit returns the physical address one cycle later. A miss spends one extra cycle reading the page table. The response flags whether the translation hit, missed or faulted. A miss with a valid table entry refills the cache. The refill takes an invalid way of the set if one exists, and otherwise takes the way named by that set's round-robin pointer. A miss on an invalid table entry raises a fault and installs nothing.

Test code fills the page table through a dedicated write port. Writing the table does not touch the cache, so stale cache entries have to be cleared with the flush input.

Top module: `mmu_xlate`

## Requirements
- R1: After reset, `resp_valid` is low, `req_ready` is high and the cache holds no mappings, so the first access to any page reports a miss.
- R2: The virtual page number is `vaddr[13:6]`. Its bits [1:0] select the cache set and its bits [7:2] form the tag. Pages with equal low bits but different tags share a set and can be resident together. Pages in different sets never evict one another.
- R3: A request accepted in cycle N that hits gives `resp_valid=1`, `resp_hit=1`, `resp_miss=0` in cycle N+1, with `resp_paddr = {cached frame, vaddr[5:0]}`.
- R4: A request accepted in cycle N that misses holds `req_ready` low in cycle N+1. It responds in cycle N+2 with `resp_miss=1`, `resp_hit=0` and the frame read from the page table.
- R5: A miss whose page-table entry is invalid responds with `resp_fault=1`, `resp_miss=1` and `resp_paddr=0`. It installs nothing, so repeating the access faults again.
- R6: After a miss with a valid table entry, the next access to the same page hits and returns the same frame.
- R7: A refill takes the lowest-numbered invalid way of its set first. Four distinct pages mapped to one set all stay resident.
- R8: When the set is full, the refill replaces the way named by that set's pointer. The pointer starts at way 0, moves up by one after each such replacement, and wraps from way 3 to way 0.
- R9: A one-cycle `flush` pulse invalidates every cache entry and returns every set pointer to way 0.
- R10: If `flush` is high in the same cycle that a refill would be written, the flush wins and the cache ends up empty. The response of that walk still carries the correct frame.
- R11: The low 6 bits of `resp_paddr` equal the low 6 bits of the translated virtual address, on both the hit path and the miss path.
- R12: With the table holding page 0x0F -> frame 0x0D and page 0x00 -> frame 0x28, address 0x03D4 translates to 0x354 and address 0x0020 translates to 0xA20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate the whole translation cache |
| req_valid | input | 1 | Translation request present |
| req_vaddr | input | 14 | Virtual address to translate |
| req_ready | output | 1 | Block can accept a request this cycle |
| resp_valid | output | 1 | Response flags and address are valid |
| resp_paddr | output | 12 | Translated physical address (0 on fault) |
| resp_hit | output | 1 | Translation came from the cache |
| resp_miss | output | 1 | Translation needed the page table |
| resp_fault | output | 1 | Page-table entry was invalid |
| pt_wr_en | input | 1 | Write one page-table entry |
| pt_wr_vpn | input | 8 | Page number of the entry written |
| pt_wr_ppn | input | 6 | Frame number stored in the entry |
| pt_wr_valid | input | 1 | Valid flag stored in the entry |

## Verification
A cache flush and a refill write can land on the same clock edge. This happens when `flush` is raised during the single walk cycle of a miss. The bench provokes it by issuing a request for an uncached page and pulsing `flush` exactly in the cycle where `req_ready` is low. It then judges the outcome at the ports. The walk response must still carry the correct frame, and a repeat access to that page must report a miss rather than a hit, which shows the flush took priority. A third access must then hit, which confirms that refill on its own still works.

// File: rtl/mmu_pkg.sv
package mmu_pkg;

    localparam int VA_W     = 14;
    localparam int PA_W     = 12;
    localparam int OFF_W    = 6;
    localparam int VPN_W    = VA_W - OFF_W;
    localparam int PPN_W    = PA_W - OFF_W;
    localparam int SETS     = 4;
    localparam int WAYS     = 4;
    localparam int SET_W    = $clog2(SETS);
    localparam int TAG_W    = VPN_W - SET_W;
    localparam int PT_DEPTH = 1 << VPN_W;

    typedef struct packed {
        logic             vld;
        logic [TAG_W-1:0] tag;
        logic [PPN_W-1:0] ppn;
    } tlb_way_t;

    typedef struct packed {
        logic             vld;
        logic [PPN_W-1:0] ppn;
    } pte_t;

    typedef enum logic {ST_IDLE, ST_WALK} mmu_state_e;

    function automatic logic [VPN_W-1:0] va_vpn(input logic [VA_W-1:0] va);
        return va[VA_W-1:OFF_W];
    endfunction

    function automatic logic [OFF_W-1:0] va_off(input logic [VA_W-1:0] va);
        return va[OFF_W-1:0];
    endfunction

    function automatic logic [SET_W-1:0] vpn_set(input logic [VPN_W-1:0] vpn);
        return vpn[SET_W-1:0];
    endfunction

    function automatic logic [TAG_W-1:0] vpn_tag(input logic [VPN_W-1:0] vpn);
        return vpn[VPN_W-1:SET_W];
    endfunction

    function automatic logic [PA_W-1:0] make_pa(input logic [PPN_W-1:0] ppn,
                                                input logic [OFF_W-1:0] off);
        return {ppn, off};
    endfunction

endpackage

// File: rtl/mmu_tlb_set.sv
module mmu_tlb_set
    import mmu_pkg::*;
#(
    parameter int NWAYS = mmu_pkg::WAYS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    input  logic             ins_en,
    input  logic [TAG_W-1:0] ins_tag,
    input  logic [PPN_W-1:0] ins_ppn
);
    localparam int WSEL_W = (NWAYS > 1) ? $clog2(NWAYS) : 1;

    tlb_way_t          ways [NWAYS];
    logic [WSEL_W-1:0] rr_ptr;
    logic [NWAYS-1:0]  hit_vec;
    logic [NWAYS-1:0]  vld_vec;
    logic              have_free;
    logic [WSEL_W-1:0] free_idx;
    logic [WSEL_W-1:0] victim;

    genvar gw;
    generate
        for (gw = 0; gw < NWAYS; gw++) begin : g_way
            assign hit_vec[gw] = ways[gw].vld && (ways[gw].tag == lk_tag);
            assign vld_vec[gw] = ways[gw].vld;
        end
    endgenerate

    always_comb begin
        lk_ppn = '0;
        for (int w = 0; w < NWAYS; w++) begin
            if (hit_vec[w]) lk_ppn = lk_ppn | ways[w].ppn;
        end
        lk_hit = |hit_vec;
    end

    // lowest-numbered invalid way wins; pointer only used when set is full
    always_comb begin
        have_free = 1'b0;
        free_idx  = '0;
        for (int w = NWAYS - 1; w >= 0; w--) begin
            if (!ways[w].vld) begin
                have_free = 1'b1;
                free_idx  = WSEL_W'(w);
            end
        end
        victim = have_free ? free_idx : rr_ptr;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            for (int w = 0; w < NWAYS; w++) begin
                ways[w] <= '0;
            end
            rr_ptr <= '0;
        end else if (ins_en) begin
            for (int w = 0; w < NWAYS; w++) begin
                if (WSEL_W'(w) == victim) begin
                    ways[w] <= '{vld: 1'b1, tag: ins_tag, ppn: ins_ppn};
                end
            end
            if (!have_free) begin
                rr_ptr <= (rr_ptr == WSEL_W'(NWAYS - 1)) ? '0 : rr_ptr + 1'b1;
            end
        end
    end

    // R6: refills happen only on misses, so a tag never lives in two ways
    p_tag_unique_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

    // R9: a flush leaves no valid way behind
    p_flush_empties_r9: assert property (@(posedge clk) disable iff (rst)
        flush |=> (vld_vec == '0));

    // R6: a written entry is visible to a lookup of the same tag next cycle
    p_install_visible_r6: assert property (@(posedge clk) disable iff (rst)
        (ins_en && !flush) |=> ((lk_tag != $past(ins_tag)) || lk_hit));

endmodule

// File: rtl/mmu_tlb.sv
module mmu_tlb
    import mmu_pkg::*;
#(
    parameter int NSETS = mmu_pkg::SETS,
    parameter int NWAYS = mmu_pkg::WAYS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    input  logic             ins_en,
    input  logic [VPN_W-1:0] ins_vpn,
    input  logic [PPN_W-1:0] ins_ppn
);
    logic [NSETS-1:0] set_hit;
    logic [PPN_W-1:0] set_ppn [NSETS];
    logic [SET_W-1:0] lk_set;
    logic [SET_W-1:0] ins_set;

    assign lk_set  = vpn_set(lk_vpn);
    assign ins_set = vpn_set(ins_vpn);

    genvar gs;
    generate
        for (gs = 0; gs < NSETS; gs++) begin : g_set
            mmu_tlb_set #(.NWAYS(NWAYS)) u_set (
                .clk     (clk),
                .rst     (rst),
                .flush   (flush),
                .lk_tag  (vpn_tag(lk_vpn)),
                .lk_hit  (set_hit[gs]),
                .lk_ppn  (set_ppn[gs]),
                .ins_en  (ins_en && (ins_set == SET_W'(gs))),
                .ins_tag (vpn_tag(ins_vpn)),
                .ins_ppn (ins_ppn)
            );
        end
    endgenerate

    assign lk_hit = set_hit[lk_set];
    assign lk_ppn = set_ppn[lk_set];

endmodule

// File: rtl/mmu_page_table.sv
module mmu_page_table
    import mmu_pkg::*;
#(
    parameter int DEPTH = mmu_pkg::PT_DEPTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PPN_W-1:0] wr_ppn,
    input  logic             wr_vld,
    input  logic [VPN_W-1:0] rd_vpn,
    output pte_t             rd_pte
);
    pte_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            mem[wr_vpn] <= '{vld: wr_vld, ppn: wr_ppn};
        end
    end

    assign rd_pte = mem[rd_vpn];

endmodule

// File: rtl/mmu_xlate.sv
module mmu_xlate
    import mmu_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            flush,
    input  logic            req_valid,
    input  logic [13:0]     req_vaddr,
    output logic            req_ready,
    output logic            resp_valid,
    output logic [11:0]     resp_paddr,
    output logic            resp_hit,
    output logic            resp_miss,
    output logic            resp_fault,
    input  logic            pt_wr_en,
    input  logic [7:0]      pt_wr_vpn,
    input  logic [5:0]      pt_wr_ppn,
    input  logic            pt_wr_valid
);
    mmu_state_e      state;
    logic [VA_W-1:0] va_q;
    logic            accept;
    logic            tlb_hit;
    logic [PPN_W-1:0] tlb_ppn;
    pte_t            pte;
    logic            refill;

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_ready && req_valid;
    assign refill    = (state == ST_WALK) && pte.vld;

    mmu_tlb u_tlb (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush),
        .lk_vpn  (va_vpn(req_vaddr)),
        .lk_hit  (tlb_hit),
        .lk_ppn  (tlb_ppn),
        .ins_en  (refill),
        .ins_vpn (va_vpn(va_q)),
        .ins_ppn (pte.ppn)
    );

    mmu_page_table u_pt (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (pt_wr_en),
        .wr_vpn (pt_wr_vpn),
        .wr_ppn (pt_wr_ppn),
        .wr_vld (pt_wr_valid),
        .rd_vpn (va_vpn(va_q)),
        .rd_pte (pte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            va_q       <= '0;
            resp_valid <= 1'b0;
            resp_paddr <= '0;
            resp_hit   <= 1'b0;
            resp_miss  <= 1'b0;
            resp_fault <= 1'b0;
        end else begin
            resp_valid <= 1'b0;
            resp_hit   <= 1'b0;
            resp_miss  <= 1'b0;
            resp_fault <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        if (tlb_hit) begin
                            resp_valid <= 1'b1;
                            resp_hit   <= 1'b1;
                            resp_paddr <= make_pa(tlb_ppn, va_off(req_vaddr));
                        end else begin
                            va_q  <= req_vaddr;
                            state <= ST_WALK;
                        end
                    end
                end
                ST_WALK: begin
                    resp_valid <= 1'b1;
                    resp_miss  <= 1'b1;
                    resp_fault <= !pte.vld;
                    resp_paddr <= pte.vld ? make_pa(pte.ppn, va_off(va_q)) : '0;
                    state      <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R1: no response flag is raised without a response
    p_quiet_when_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !resp_valid |-> (!resp_hit && !resp_miss && !resp_fault));

    // R3: hit answered on the next cycle
    p_hit_latency_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && req_valid && tlb_hit) |=> (resp_valid && resp_hit));

    // R3: exactly one of hit or miss on every response
    p_hit_xor_miss_r3: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> (resp_hit != resp_miss));

    // R4: the walk takes exactly one cycle and ends with a miss response
    p_walk_single_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WALK) |=> (resp_valid && resp_miss && req_ready));

    // R5: a fault is always a miss response
    p_fault_is_miss_r5: assert property (@(posedge clk) disable iff (rst)
        resp_fault |-> (resp_valid && resp_miss && !resp_hit));

    // R11: walk result keeps the page offset of the latched address
    p_offset_walk_r11: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WALK && pte.vld) |=> (resp_paddr[OFF_W-1:0] == $past(va_q[OFF_W-1:0])));

endmodule

// File: tb/mmu_xlate_bench.sv
`timescale 1ns/1ps
module mmu_xlate_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        flush;
    logic        req_valid;
    logic [13:0] req_vaddr;
    logic        req_ready;
    logic        resp_valid;
    logic [11:0] resp_paddr;
    logic        resp_hit;
    logic        resp_miss;
    logic        resp_fault;
    logic        pt_wr_en;
    logic [7:0]  pt_wr_vpn;
    logic [5:0]  pt_wr_ppn;
    logic        pt_wr_valid;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    mmu_xlate u_mmu_xlate (
        .clk(clk), .rst(rst), .flush(flush),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_ready(req_ready),
        .resp_valid(resp_valid), .resp_paddr(resp_paddr),
        .resp_hit(resp_hit), .resp_miss(resp_miss), .resp_fault(resp_fault),
        .pt_wr_en(pt_wr_en), .pt_wr_vpn(pt_wr_vpn), .pt_wr_ppn(pt_wr_ppn),
        .pt_wr_valid(pt_wr_valid)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic pt_write(input logic [7:0] vpn, input logic [5:0] ppn, input logic vld);
        @(negedge clk);
        pt_wr_en = 1'b1; pt_wr_vpn = vpn; pt_wr_ppn = ppn; pt_wr_valid = vld;
        @(negedge clk);
        pt_wr_en = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    // one access; checks flags, latency, ready during walk, and address
    task automatic access(input string req, input logic [13:0] va,
                          input bit exp_hit, input bit exp_fault, input logic [11:0] exp_pa);
        int lat;
        logic rdy_walk;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        rdy_walk = req_ready;
        while (!resp_valid && lat < 8) begin
            @(negedge clk);
            lat++;
        end
        chk({req, " resp_valid"}, int'(resp_valid), 1);
        chk({req, " hit"},  int'(resp_hit),  int'(exp_hit));
        chk({req, " miss"}, int'(resp_miss), int'(!exp_hit));
        chk({req, " fault"}, int'(resp_fault), int'(exp_fault));
        chk({req, " latency"}, lat, exp_hit ? 1 : 2);
        if (!exp_hit) chk({req, " R4 ready low in walk"}, int'(rdy_walk), 0);
        chk({req, " paddr"}, int'(resp_paddr), int'(exp_pa));
    endtask

    function automatic logic [13:0] va_of(input logic [7:0] vpn, input logic [5:0] off);
        return {vpn, off};
    endfunction

    function automatic logic [11:0] pa_of(input logic [5:0] ppn, input logic [5:0] off);
        return {ppn, off};
    endfunction

    task automatic t_reset();
        @(negedge clk);
        chk("R1 resp_valid after reset", int'(resp_valid), 0);
        chk("R1 req_ready after reset", int'(req_ready), 1);
    endtask

    task automatic t_example();
        pt_write(8'h0F, 6'h0D, 1'b1);
        pt_write(8'h00, 6'h28, 1'b1);
        pt_write(8'h01, 6'h00, 1'b0);
        access("R1 R12 first 0x03D4", 14'h03D4, 1'b0, 1'b0, 12'h354);
        access("R3 R6 R12 repeat 0x03D4", 14'h03D4, 1'b1, 1'b0, 12'h354);
        access("R4 R12 0x0020", 14'h0020, 1'b0, 1'b0, 12'hA20);
        access("R6 R3 repeat 0x0020", 14'h0020, 1'b1, 1'b0, 12'hA20);
    endtask

    task automatic t_fault();
        access("R5 fault 0x0045", 14'h0045, 1'b0, 1'b1, 12'h000);
        access("R5 fault again", 14'h0045, 1'b0, 1'b1, 12'h000);
    endtask

    task automatic t_offset();
        access("R11 hit offset 0", va_of(8'h0F, 6'h00), 1'b1, 1'b0, pa_of(6'h0D, 6'h00));
        access("R11 hit offset 3F", va_of(8'h0F, 6'h3F), 1'b1, 1'b0, pa_of(6'h0D, 6'h3F));
    endtask

    task automatic t_flush();
        do_flush();
        access("R9 after flush 0x03D4", 14'h03D4, 1'b0, 1'b0, 12'h354);
        access("R9 after flush 0x0020", 14'h0020, 1'b0, 1'b0, 12'hA20);
    endtask

    // set 1: pages 0x05 0x09 0x0D 0x11 0x15 (tags 1..5), frames 0x21..0x25
    task automatic t_replace();
        logic [7:0] pg [5] = '{8'h05, 8'h09, 8'h0D, 8'h11, 8'h15};
        for (int i = 0; i < 5; i++) pt_write(pg[i], 6'(8'h21 + i), 1'b1);
        pt_write(8'h06, 6'h30, 1'b1);
        do_flush();
        for (int i = 0; i < 4; i++)
            access("R7 fill set 1", va_of(pg[i], 6'(i)), 1'b0, 1'b0, pa_of(6'(8'h21 + i), 6'(i)));
        for (int i = 0; i < 4; i++)
            access("R7 R2 all four resident", va_of(pg[i], 6'h11), 1'b1, 1'b0, pa_of(6'(8'h21 + i), 6'h11));
        access("R2 other set miss 0x06", va_of(8'h06, 6'h02), 1'b0, 1'b0, pa_of(6'h30, 6'h02));
        access("R2 set 1 untouched", va_of(8'h05, 6'h00), 1'b1, 1'b0, pa_of(6'h21, 6'h00));
        access("R8 fifth page evicts way0", va_of(8'h15, 6'h00), 1'b0, 1'b0, pa_of(6'h25, 6'h00));
        access("R8 0x09 kept", va_of(8'h09, 6'h00), 1'b1, 1'b0, pa_of(6'h22, 6'h00));
        access("R8 0x11 kept", va_of(8'h11, 6'h00), 1'b1, 1'b0, pa_of(6'h24, 6'h00));
        access("R8 0x05 evicted", va_of(8'h05, 6'h00), 1'b0, 1'b0, pa_of(6'h21, 6'h00));
        access("R8 0x0D kept", va_of(8'h0D, 6'h00), 1'b1, 1'b0, pa_of(6'h23, 6'h00));
        access("R8 0x09 evicted by way1", va_of(8'h09, 6'h00), 1'b0, 1'b0, pa_of(6'h22, 6'h00));
        access("R8 0x11 still kept", va_of(8'h11, 6'h00), 1'b1, 1'b0, pa_of(6'h24, 6'h00));
        access("R8 0x0D evicted by way2", va_of(8'h0D, 6'h00), 1'b0, 1'b0, pa_of(6'h23, 6'h00));
        access("R8 0x11 evicted by way3", va_of(8'h11, 6'h00), 1'b0, 1'b0, pa_of(6'h24, 6'h00));
    endtask

    task automatic t_flush_refill();
        pt_write(8'h1E, 6'h3A, 1'b1);
        do_flush();
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va_of(8'h1E, 6'h05);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 walk cycle ready low", int'(req_ready), 0);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        chk("R10 walk resp_valid", int'(resp_valid), 1);
        chk("R10 walk miss", int'(resp_miss), 1);
        chk("R10 walk paddr", int'(resp_paddr), int'(pa_of(6'h3A, 6'h05)));
        access("R10 flush won, miss", va_of(8'h1E, 6'h06), 1'b0, 1'b0, pa_of(6'h3A, 6'h06));
        access("R10 refill alone works", va_of(8'h1E, 6'h07), 1'b1, 1'b0, pa_of(6'h3A, 6'h07));
    endtask

    initial begin
        rst = 1'b1; flush = 1'b0; req_valid = 1'b0; req_vaddr = '0;
        pt_wr_en = 1'b0; pt_wr_vpn = '0; pt_wr_ppn = '0; pt_wr_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_example();
        t_fault();
        t_offset();
        t_flush();
        t_replace();
        t_flush_refill();
        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

endmodule